// File: doc/BRIEF.md
# Serial PCM Transmit Port

This block places one companded sample per frame on a serial line that several devices share. An upstream compressor presents an 8-bit code word. A rising edge on the transmit frame strobe captures that word. The port then sends the word most significant bit first, one bit for each rising edge of the transmit bit clock. The bit clock may run all the time, or it may come in bursts of at least nine edges per frame. The line is driven only during the eight bit periods of the slot. The rest of the time the output enable is low, so other transmitters can use the same wire.

All inputs are sampled on a free-running reference clock `clk`. The bit clock and the frame strobe are level signals on that clock, and the port detects their rising edges. A line-coding option inverts the even-numbered bits of the word (bit 1 is the MSB), as A-law trunks require. The transmitter shuts down in two cases: the frame strobe stops toggling for `SYNC_TIMEOUT` reference cycles, or the power-down input stays low for `PDN_CYCLES` consecutive reference cycles.

Top module: `pcm_tx_port`

## Requirements
- R1: While the slot is open, each rising edge of `tx_bclk` puts the next bit of the captured word on `pcm_data`, MSB first. Between those edges `pcm_data` does not change.
- R2: `pcm_oe` goes high with the first bit and stays high for exactly eight bit periods. The rising edge of `tx_bclk` that follows the eighth bit clears it. Further clock edges in the same frame do not drive the line.
- R3: If `tx_bclk` is already high when `tx_sync` rises, the first bit is launched by the frame strobe edge itself, without waiting for a clock edge. If `tx_bclk` is low at that moment, the first bit waits for the next rising edge of `tx_bclk`.
- R4: When `alaw_en` is 1 at the frame strobe edge, bits 2, 4, 6 and 8 (bit 1 is the MSB) are sent inverted. For an 8-bit word this is an XOR with 0x55. When `alaw_en` is 0, the word is sent unchanged.
- R5: A burst of nine `tx_bclk` rising edges carries a complete frame: eight bits, then release of the line.
- R6: The word is captured at the frame strobe edge. A change of `sample_in` later in the slot has no effect on the bits sent.
- R7: A new rising edge of `tx_sync` during a slot abandons the old word and starts a new frame with the current `sample_in`.
- R8: If `tx_sync` has no rising edge for `SYNC_TIMEOUT` reference cycles, `tx_pwrdn` goes to 1 and the line stays undriven. The next rising edge of `tx_sync` clears `tx_pwrdn` and discards that frame. The frame after it is sent normally.
- R9: `pdn_n` held low for `PDN_CYCLES` consecutive reference cycles sets `tx_pwrdn` and stops transmission. A shorter low pulse has no effect. The first high sample of `pdn_n` clears the power-down.
- R10: Whenever `pcm_oe` is 0, `pcm_data` is 0. During reset, `pcm_oe`, `pcm_data` and `tx_pwrdn` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_bclk | input | 1 | Transmit bit clock, sampled on `clk` |
| tx_sync | input | 1 | Frame strobe; a rising edge starts a frame |
| alaw_en | input | 1 | Even-bit inversion enable, sampled at the frame strobe edge |
| pdn_n | input | 1 | Power-down request, active low |
| sample_in | input | WORD_W | Companded code word from the compressor |
| pcm_data | output | 1 | Serial bit value |
| pcm_oe | output | 1 | Line drive enable; 0 means the line is released |
| tx_pwrdn | output | 1 | Transmitter is in power-down |

## Verification
The assertions check four properties on every cycle:
- the line is quiet while `pcm_oe` is low;
- the line is released one cycle after `tx_pwrdn` is seen;
- drive begins only at a bit-clock or strobe edge, and the data holds between edges;
- at most seven bit-clock edges arrive while the slot is open.

Some behaviour is visible only in the bench scenarios, which compare against a queue-based reference model:
- the actual bit order and A-law coding;
- launch of the first bit from the strobe edge;
- the captured word staying unchanged after `sample_in` moves;
- the wake frame being discarded after a stalled strobe;
- the exact qualification lengths for power-down.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_ARMED = 2'd1,
    SL_SHIFT = 2'd2
  } slot_state_t;

endpackage

// File: rtl/pcm_tx_pwr_mon.sv
module pcm_tx_pwr_mon #(
  parameter int PDN_CYCLES   = 1000,
  parameter int SYNC_TIMEOUT = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic pdn_n,
  input  logic sync_rise,
  output logic pdn_hit,
  output logic sync_dead
);
  localparam int PW = $clog2(PDN_CYCLES + 1);
  localparam int AW = $clog2(SYNC_TIMEOUT + 1);
  localparam logic [PW-1:0] PDN_MAX = PW'(PDN_CYCLES);
  localparam logic [PW-1:0] PDN_THR = PW'(PDN_CYCLES - 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(SYNC_TIMEOUT);
  localparam logic [AW-1:0] AGE_THR = AW'(SYNC_TIMEOUT - 1);

  logic [PW-1:0] low_run;
  logic [AW-1:0] sync_age;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
      pdn_hit <= 1'b0;
    end else if (!pdn_n) begin
      if (low_run != PDN_MAX) low_run <= low_run + 1'b1;
      pdn_hit <= (low_run >= PDN_THR);
    end else begin
      low_run <= '0;
      pdn_hit <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_age  <= '0;
      sync_dead <= 1'b0;
    end else if (sync_rise) begin
      sync_age  <= '0;
      sync_dead <= 1'b0;
    end else begin
      if (sync_age != AGE_MAX) sync_age <= sync_age + 1'b1;
      sync_dead <= (sync_age >= AGE_THR);
    end
  end

endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              bclk_lvl,
  input  logic              bclk_rise,
  input  logic              sync_rise,
  input  logic              alaw_en,
  input  logic [WORD_W-1:0] sample_in,
  output logic              pcm_data,
  output logic              pcm_oe
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_W);

  slot_state_t       state;
  logic [CW-1:0]     sent;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] coded;

  // Bit number n counts from the MSB (n = WORD_W - i); even n is inverted
  for (genvar i = 0; i < WORD_W; i++) begin : g_code
    if (((WORD_W - i) % 2) == 0) begin : g_inv
      assign coded[i] = sample_in[i] ^ alaw_en;
    end else begin : g_pass
      assign coded[i] = sample_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      state    <= SL_IDLE;
      sent     <= '0;
      shreg    <= '0;
      pcm_data <= 1'b0;
      pcm_oe   <= 1'b0;
    end else if (sync_rise) begin
      if (bclk_lvl) begin
        state    <= SL_SHIFT;
        sent     <= CW'(1);
        shreg    <= coded << 1;
        pcm_data <= coded[WORD_W-1];
        pcm_oe   <= 1'b1;
      end else begin
        state    <= SL_ARMED;
        sent     <= '0;
        shreg    <= coded;
        pcm_data <= 1'b0;
        pcm_oe   <= 1'b0;
      end
    end else if (bclk_rise) begin
      case (state)
        SL_ARMED, SL_SHIFT: begin
          if (sent == LAST) begin
            state    <= SL_IDLE;
            sent     <= '0;
            pcm_data <= 1'b0;
            pcm_oe   <= 1'b0;
          end else begin
            state    <= SL_SHIFT;
            sent     <= sent + 1'b1;
            shreg    <= shreg << 1;
            pcm_data <= shreg[WORD_W-1];
            pcm_oe   <= 1'b1;
          end
        end
        default: begin
          pcm_data <= 1'b0;
          pcm_oe   <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
  parameter int WORD_W       = 8,
  parameter int PDN_CYCLES   = 1000,
  parameter int SYNC_TIMEOUT = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_bclk,
  input  logic              tx_sync,
  input  logic              alaw_en,
  input  logic              pdn_n,
  input  logic [WORD_W-1:0] sample_in,
  output logic              pcm_data,
  output logic              pcm_oe,
  output logic              tx_pwrdn
);
  logic bclk_q, sync_q;
  logic bclk_rise, sync_rise;
  logic pdn_hit, sync_dead;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      bclk_q <= tx_bclk;
      sync_q <= tx_sync;
    end
  end

  assign bclk_rise = tx_bclk & ~bclk_q;
  assign sync_rise = tx_sync & ~sync_q;
  assign tx_pwrdn  = pdn_hit | sync_dead;

  pcm_tx_pwr_mon #(
    .PDN_CYCLES  (PDN_CYCLES),
    .SYNC_TIMEOUT(SYNC_TIMEOUT)
  ) u_pwr (
    .clk      (clk),
    .rst      (rst),
    .pdn_n    (pdn_n),
    .sync_rise(sync_rise),
    .pdn_hit  (pdn_hit),
    .sync_dead(sync_dead)
  );

  pcm_tx_shifter #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .halt     (tx_pwrdn),
    .bclk_lvl (tx_bclk),
    .bclk_rise(bclk_rise),
    .sync_rise(sync_rise),
    .alaw_en  (alaw_en),
    .sample_in(sample_in),
    .pcm_data (pcm_data),
    .pcm_oe   (pcm_oe)
  );

endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk #(
  parameter int WORD_W = 8
) (
  input logic clk,
  input logic rst,
  input logic tx_bclk,
  input logic tx_sync,
  input logic pcm_data,
  input logic pcm_oe,
  input logic tx_pwrdn
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] MAX_OPEN = CW'(WORD_W - 1);

  logic b_q, s_q, b_rise, s_rise;
  logic [CW-1:0] open_edges;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_q <= 1'b0;
      s_q <= 1'b0;
    end else begin
      b_q <= tx_bclk;
      s_q <= tx_sync;
    end
  end
  assign b_rise = tx_bclk & ~b_q;
  assign s_rise = tx_sync & ~s_q;

  always_ff @(posedge clk) begin
    if (rst || s_rise || !pcm_oe) open_edges <= '0;
    else if (b_rise && open_edges != '1) open_edges <= open_edges + 1'b1;
  end

  assert_quiet_when_released_R10: assert property (@(posedge clk) disable iff (rst)
    !pcm_oe |-> !pcm_data);

  assert_release_in_pwrdn_R8: assert property (@(posedge clk) disable iff (rst)
    tx_pwrdn |=> !pcm_oe);

  assert_drive_starts_on_edge_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pcm_oe) |-> $past(b_rise || s_rise));

  assert_bit_held_between_edges_R1: assert property (@(posedge clk) disable iff (rst)
    (pcm_oe && $past(pcm_oe) && !$past(b_rise) && !$past(s_rise)) |-> $stable(pcm_data));

  assert_slot_length_R2: assert property (@(posedge clk) disable iff (rst)
    pcm_oe |-> (open_edges <= MAX_OPEN));

endmodule

bind pcm_tx_port pcm_tx_port_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_bclk (tx_bclk),
  .tx_sync (tx_sync),
  .pcm_data(pcm_data),
  .pcm_oe  (pcm_oe),
  .tx_pwrdn(tx_pwrdn)
);

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int PDN = 40;
  localparam int TO  = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_bclk = 1'b0, tx_sync = 1'b0, alaw_en = 1'b0, pdn_n = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic pcm_data, pcm_oe, tx_pwrdn;

  int checks = 0, fails = 0;
  string cur_req = "R10";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_tx_port #(.WORD_W(W), .PDN_CYCLES(PDN), .SYNC_TIMEOUT(TO)) u_dut (
    .clk(clk), .rst(rst), .tx_bclk(tx_bclk), .tx_sync(tx_sync),
    .alaw_en(alaw_en), .pdn_n(pdn_n), .sample_in(sample_in),
    .pcm_data(pcm_data), .pcm_oe(pcm_oe), .tx_pwrdn(tx_pwrdn));

  // ---------------- behavioural reference ----------------
  bit m_pb, m_ps, m_active, m_hit, m_dead;
  int m_low, m_since;
  bit q[$];
  logic e_oe, e_d, e_pd;

  always @(posedge clk) begin
    bit br, sr;
    if (rst) begin
      m_pb = 0; m_ps = 0; m_active = 0; m_hit = 0; m_dead = 0;
      m_low = 0; m_since = 0; q.delete();
      e_oe = 0; e_d = 0; e_pd = 0;
    end else begin
      br = tx_bclk && !m_pb;
      sr = tx_sync && !m_ps;
      if (m_hit || m_dead) begin
        m_active = 0; q.delete(); e_oe = 0; e_d = 0;
      end else if (sr) begin
        q.delete();
        for (int n = 1; n <= W; n++)
          q.push_back(sample_in[W-n] ^ (alaw_en && (n % 2 == 0)));
        m_active = 1;
        if (tx_bclk) begin e_d = q.pop_front(); e_oe = 1; end
        else begin e_d = 0; e_oe = 0; end
      end else if (m_active && br) begin
        if (q.size() == 0) begin m_active = 0; e_oe = 0; e_d = 0; end
        else begin e_d = q.pop_front(); e_oe = 1; end
      end
      if (!pdn_n) begin m_low++; m_hit = (m_low >= PDN); end
      else begin m_low = 0; m_hit = 0; end
      if (sr) begin m_since = 0; m_dead = 0; end
      else begin m_since++; m_dead = (m_since >= TO); end
      e_pd = m_hit || m_dead;
      m_pb = tx_bclk; m_ps = tx_sync;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (pcm_oe !== e_oe || pcm_data !== e_d || tx_pwrdn !== e_pd) begin
        fails++;
        $display("FAIL %s t=%0t oe/data/pwrdn actual=%b%b%b expected=%b%b%b",
                 cur_req, $time, pcm_oe, pcm_data, tx_pwrdn, e_oe, e_d, e_pd);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(); @(posedge clk); #1; endtask
  task automatic bpulse();
    tx_bclk = 1; tick(); tick(); tx_bclk = 0; tick(); tick();
  endtask
  // sync while bit clock low; first bit on next clock edge
  task automatic frame_early(input logic [W-1:0] w, input int edges);
    sample_in = w; tx_sync = 1; tick();
    for (int k = 0; k < edges; k++) begin
      bpulse();
      if (k == 0) tx_sync = 0;
    end
  endtask
  // sync rises while bit clock already high; first bit from the strobe
  task automatic frame_late(input logic [W-1:0] w, input int edges);
    tx_bclk = 1; tick();
    sample_in = w; tx_sync = 1; tick();
    tx_bclk = 0; tick(); tick(); tx_sync = 0;
    for (int k = 1; k < edges; k++) bpulse();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R10";
    repeat (4) tick();
    rst = 0; tick();
    cur_req = "R1";
    frame_early(8'hA5, 10);
    frame_early(8'h3C, 10);
    cur_req = "R2";
    frame_early(8'hFF, 12);
    frame_early(8'h00, 10);
    cur_req = "R3";
    frame_late(8'hC3, 9);
    frame_late(8'h81, 10);
    cur_req = "R4";
    alaw_en = 1;
    frame_early(8'h00, 9);
    frame_late(8'hF0, 9);
    alaw_en = 0;
    cur_req = "R5";
    frame_early(8'h5A, 9);
    repeat (20) tick();
    cur_req = "R6";
    sample_in = 8'h96; tx_sync = 1; tick();
    sample_in = 8'h69; bpulse(); tx_sync = 0;
    sample_in = 8'h0F;
    for (int k = 0; k < 8; k++) bpulse();
    cur_req = "R7";
    sample_in = 8'hE7; tx_sync = 1; tick();
    bpulse(); tx_sync = 0; bpulse(); bpulse();
    frame_early(8'h18, 9);
    cur_req = "R10";
    repeat (10) bpulse();
    cur_req = "R8";
    repeat (90) bpulse();
    frame_early(8'hAA, 9);
    frame_early(8'h55, 9);
    cur_req = "R9";
    pdn_n = 0; repeat (PDN - 5) tick(); pdn_n = 1; tick();
    frame_early(8'hB4, 9);
    pdn_n = 0; repeat (PDN + 2) tick();
    frame_early(8'h4B, 9);
    pdn_n = 1; tick();
    frame_early(8'hD2, 9);
    repeat (4) tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule